// File: doc/BRIEF.md
# Bitwise Logic Unit with Status Flags

This block performs the bitwise operations of a small processor datapath on two operands: AND, OR, XOR, ones' complement (NOT) and a flag-only AND probe (TEST). A width select picks byte or word operation. One strobed request produces a registered result, a registered destination write-enable, and six registered status flags: zero, sign, parity, carry, overflow and auxiliary.

Each operation updates the flags under its own rule. The three two-operand operations and TEST derive zero, sign and parity from the result and force carry and overflow low. NOT writes the complement and leaves every flag as it was. TEST updates the flags from the AND of its operands but never asks for the destination to be written. The auxiliary flag has no defined meaning after these operations, so it is driven to a fixed value (parameter `AUX_FILL`, default 0).

The block is meant to sit after operand fetch and in front of register write-back. Its outputs change one clock after a strobe. Between strobes the result and the flags hold, and the write-enable stays low.

Top module: `bitlogic_unit`

## Requirements
- R1: While `rst_n` is low, `result`, `wr_en` and all six flag outputs are 0.
- R2: With `op_valid` high at a rising edge, op code 0 (AND), 1 (OR), 2 (XOR) or 3 (NOT, complement of `dst_a`) puts its result on `result` after that edge and raises `wr_en` for exactly that one cycle (for example 0x4C with 0x2D gives 0x0C, 0x6D and 0x61 for codes 0, 1 and 2).
- R3: With `wide` = 0 only bits 7:0 of the operands take part and `result[15:8]` is 0. With `wide` = 1 all 16 bits are used.
- R4: After codes 0, 1, 2 and 4, `flag_zero` is 1 exactly when the result of the selected width is zero.
- R5: After codes 0, 1, 2 and 4, `flag_sign` equals result bit 7 when `wide` = 0 and bit 15 when `wide` = 1.
- R6: After codes 0, 1, 2 and 4, `flag_parity` is 1 exactly when result bits 7:0 hold an even number of ones, in either width.
- R7: Codes 0, 1, 2 and 4 clear `flag_carry` and `flag_ovf`.
- R8: `flag_aux` is always equal to `AUX_FILL` (0 by default), including after every flag-updating operation.
- R9: Code 3 (NOT) leaves all six flags unchanged.
- R10: Code 4 (TEST) sets the flags from the AND of the operands, keeps `wr_en` low and leaves `result` at its previous value.
- R11: A cycle with `op_valid` low, or with op code 5, 6 or 7, keeps `wr_en` low and leaves `result` and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe, one operation per high cycle |
| op_sel | input | 3 | Operation code: 0 AND, 1 OR, 2 XOR, 3 NOT, 4 TEST |
| wide | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit operation |
| dst_a | input | 16 | Destination operand, the only operand of NOT |
| src_b | input | 16 | Source operand or mask |
| result | output | 16 | Registered result |
| wr_en | output | 1 | Destination write-enable, high one cycle per writing operation |
| flag_zero | output | 1 | Zero flag |
| flag_sign | output | 1 | Sign flag |
| flag_parity | output | 1 | Even-parity flag of the low result byte |
| flag_carry | output | 1 | Carry flag |
| flag_ovf | output | 1 | Overflow flag |
| flag_aux | output | 1 | Auxiliary flag, fixed value |

## Verification
All outputs come straight from state registers, so a wrong next-state value shows at the ports in the cycle after the strobe that caused it. A flag register that fails to hold is different. NOT, idle cycles and undefined codes must leave the flags alone, and a corruption there stays hidden until the flags are read. The bench therefore checks every flag after every cycle, including the cycles that should change nothing. It sweeps every byte value of the destination against several masks for all five operations, and then runs a set of word-width patterns.

// File: rtl/bitlogic_pkg.sv
`timescale 1ns/1ps
package bitlogic_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_XOR  = 3'd2,
        OP_NOT  = 3'd3,
        OP_TEST = 3'd4
    } lop_e;

    typedef enum logic [1:0] {
        FN_AND = 2'd0,
        FN_OR  = 2'd1,
        FN_XOR = 2'd2,
        FN_INV = 2'd3
    } lfn_e;

    typedef struct packed {
        logic known;      // op code is defined
        logic write;      // result goes to destination
        logic upd_flags;  // flags load from this operation
        lfn_e fn;         // datapath function
    } lctl_t;

    typedef struct packed {
        logic zf;
        logic sf;
        logic pf;
        logic cf;
        logic of;
        logic af;
    } lflags_t;

endpackage

// File: rtl/bitlogic_decode.sv
`timescale 1ns/1ps
module bitlogic_decode
    import bitlogic_pkg::*;
(
    input  logic [2:0] op_code,
    output lctl_t      ctl
);
    always_comb begin
        ctl = '{known: 1'b0, write: 1'b0, upd_flags: 1'b0, fn: FN_AND};
        case (op_code)
            OP_AND:  ctl = '{known: 1'b1, write: 1'b1, upd_flags: 1'b1, fn: FN_AND};
            OP_OR:   ctl = '{known: 1'b1, write: 1'b1, upd_flags: 1'b1, fn: FN_OR};
            OP_XOR:  ctl = '{known: 1'b1, write: 1'b1, upd_flags: 1'b1, fn: FN_XOR};
            OP_NOT:  ctl = '{known: 1'b1, write: 1'b1, upd_flags: 1'b0, fn: FN_INV};
            OP_TEST: ctl = '{known: 1'b1, write: 1'b0, upd_flags: 1'b1, fn: FN_AND};
            default: ctl = '{known: 1'b0, write: 1'b0, upd_flags: 1'b0, fn: FN_AND};
        endcase
    end
endmodule

// File: rtl/bitlogic_datapath.sv
`timescale 1ns/1ps
module bitlogic_datapath
    import bitlogic_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  lfn_e              fn,
    input  logic              wide,
    output logic [DATA_W-1:0] res
);
    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] raw;

    // Lanes above the narrow width survive only in wide mode.
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        if (i < NARROW_W) begin : g_low
            assign keep[i] = 1'b1;
        end else begin : g_high
            assign keep[i] = wide;
        end
    end

    always_comb begin
        case (fn)
            FN_AND:  raw = opa & opb;
            FN_OR:   raw = opa | opb;
            FN_XOR:  raw = opa ^ opb;
            default: raw = ~opa;
        endcase
        res = raw & keep;
    end
endmodule

// File: rtl/bitlogic_flaggen.sv
`timescale 1ns/1ps
module bitlogic_flaggen #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int PAR_W    = 8
) (
    input  logic [DATA_W-1:0] res,
    input  logic              wide,
    output logic              zf,
    output logic              sf,
    output logic              pf
);
    localparam int SIGN_HI = DATA_W - 1;
    localparam int SIGN_LO = NARROW_W - 1;

    always_comb begin
        zf = ~|res;
        sf = wide ? res[SIGN_HI] : res[SIGN_LO];
        pf = ~^res[PAR_W-1:0];
    end
endmodule

// File: rtl/bitlogic_unit.sv
`timescale 1ns/1ps
module bitlogic_unit
    import bitlogic_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter bit AUX_FILL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_sel,
    input  logic              wide,
    input  logic [DATA_W-1:0] dst_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              flag_zero,
    output logic              flag_sign,
    output logic              flag_parity,
    output logic              flag_carry,
    output logic              flag_ovf,
    output logic              flag_aux
);
    localparam int PAR_W = (NARROW_W < DATA_W) ? NARROW_W : DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              wr;
        lflags_t           flg;
    } lstate_t;

    lstate_t st_d, st_q;
    lctl_t   ctl;
    logic [DATA_W-1:0] fn_res;
    logic    g_zf, g_sf, g_pf;

    bitlogic_decode i_decode (
        .op_code (op_sel),
        .ctl     (ctl)
    );

    bitlogic_datapath #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) i_datapath (
        .opa  (dst_a),
        .opb  (src_b),
        .fn   (ctl.fn),
        .wide (wide),
        .res  (fn_res)
    );

    bitlogic_flaggen #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .PAR_W    (PAR_W)
    ) i_flaggen (
        .res  (fn_res),
        .wide (wide),
        .zf   (g_zf),
        .sf   (g_sf),
        .pf   (g_pf)
    );

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        if (op_valid && ctl.known) begin
            st_d.wr = ctl.write;
            if (ctl.write) begin
                st_d.res = fn_res;
            end
            if (ctl.upd_flags) begin
                st_d.flg.zf = g_zf;
                st_d.flg.sf = g_sf;
                st_d.flg.pf = g_pf;
                st_d.flg.cf = 1'b0;
                st_d.flg.of = 1'b0;
                st_d.flg.af = AUX_FILL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result      = st_q.res;
    assign wr_en       = st_q.wr;
    assign flag_zero   = st_q.flg.zf;
    assign flag_sign   = st_q.flg.sf;
    assign flag_parity = st_q.flg.pf;
    assign flag_carry  = st_q.flg.cf;
    assign flag_ovf    = st_q.flg.of;
    assign flag_aux    = st_q.flg.af;
endmodule

// File: rtl/bitlogic_unit_chk.sv
`timescale 1ns/1ps
module bitlogic_unit_chk #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter bit AUX_FILL = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_sel,
    input logic              wide,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic              flag_zero,
    input logic              flag_sign,
    input logic              flag_parity,
    input logic              flag_carry,
    input logic              flag_ovf,
    input logic              flag_aux
);
    logic [5:0] flags;
    logic       two_op;
    logic       upd;
    logic       writes;

    assign flags  = {flag_zero, flag_sign, flag_parity, flag_carry, flag_ovf, flag_aux};
    assign two_op = op_valid && (op_sel <= 3'd2);
    assign upd    = two_op || (op_valid && op_sel == 3'd4);
    assign writes = op_valid && (op_sel <= 3'd3);

    AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        writes |=> wr_en);                                                   // R2
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (writes && !wide) |=> (result[DATA_W-1:NARROW_W] == '0));           // R3
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        two_op |=> (flag_zero == (result == '0)));                          // R4
    AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        two_op |=> (flag_parity == ~^result[NARROW_W-1:0]));                // R6
    AST_CARRY_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (!flag_carry && !flag_ovf));                                // R7
    AST_AUX_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        flag_aux == AUX_FILL);                                              // R8
    AST_NOT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd3) |=> $stable(flags));                   // R9
    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd4) |=> (!wr_en && $stable(result)));      // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_sel > 3'd4) |=> (!wr_en && $stable(result) && $stable(flags))); // R11
endmodule

bind bitlogic_unit bitlogic_unit_chk #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .AUX_FILL (AUX_FILL)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_sel      (op_sel),
    .wide        (wide),
    .result      (result),
    .wr_en       (wr_en),
    .flag_zero   (flag_zero),
    .flag_sign   (flag_sign),
    .flag_parity (flag_parity),
    .flag_carry  (flag_carry),
    .flag_ovf    (flag_ovf),
    .flag_aux    (flag_aux)
);

// File: tb/test_bitlogic_unit.sv
`timescale 1ns/1ps
module test_bitlogic_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic        wide = 1'b0;
    logic [15:0] dst_a = 16'h0;
    logic [15:0] src_b = 16'h0;
    logic [15:0] result;
    logic        wr_en;
    logic        flag_zero, flag_sign, flag_parity, flag_carry, flag_ovf, flag_aux;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] m_res = 16'h0;
    logic        m_wr  = 1'b0;
    logic [5:0]  m_flg = 6'h0;   // {zf, sf, pf, cf, of, af}

    always #2.5 clk = ~clk;

    bitlogic_unit i_bitlogic_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .wide(wide), .dst_a(dst_a), .src_b(src_b), .result(result),
        .wr_en(wr_en), .flag_zero(flag_zero), .flag_sign(flag_sign),
        .flag_parity(flag_parity), .flag_carry(flag_carry),
        .flag_ovf(flag_ovf), .flag_aux(flag_aux)
    );

    task automatic check(input string tag, input logic [22:0] act, input logic [22:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual res=%h wr=%b flags=%b expected res=%h wr=%b flags=%b",
                     tag, act[22:7], act[6], act[5:0], exp[22:7], exp[6], exp[5:0]);
        end
    endtask

    function automatic string tag_for(input logic [2:0] op);
        case (op)
            3'd0, 3'd1, 3'd2: return "R2 R4 R5 R6 R7 R8";
            3'd3:             return "R2 R9";
            3'd4:             return "R10 R4 R5 R6 R7";
            default:          return "R11";
        endcase
    endfunction

    // Called at a falling edge: drive, update model, check at next falling edge.
    task automatic apply(input logic v, input logic [2:0] op, input logic w,
                         input logic [15:0] a, input logic [15:0] b, input string extra);
        logic [15:0] mask, am, bm, r;
        int ones;
        op_valid = v; op_sel = op; wide = w; dst_a = a; src_b = b;
        mask = w ? 16'hFFFF : 16'h00FF;
        am = a & mask;
        bm = b & mask;
        r  = 16'h0;
        m_wr = 1'b0;
        if (v && op <= 3'd4) begin
            case (op)
                3'd0:    r = am & bm;
                3'd1:    r = am | bm;
                3'd2:    r = am ^ bm;
                3'd3:    r = (~am) & mask;
                default: r = am & bm;
            endcase
            if (op != 3'd4) begin
                m_res = r;
                m_wr  = 1'b1;
            end
            if (op != 3'd3) begin
                ones = 0;
                for (int k = 0; k < 8; k++) ones += int'(r[k]);
                m_flg[5] = (r == 16'h0);
                m_flg[4] = w ? (r >= 16'h8000) : (r >= 16'h0080);
                m_flg[3] = (ones % 2 == 0);
                m_flg[2:0] = 3'b000;
            end
        end
        @(negedge clk);
        check({tag_for(v ? op : 3'd7), extra},
              {result, wr_en, flag_zero, flag_sign, flag_parity, flag_carry, flag_ovf, flag_aux},
              {m_res, m_wr, m_flg});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {result, wr_en, flag_zero, flag_sign, flag_parity, flag_carry,
              flag_ovf, flag_aux}, 23'h0);
        rst_n = 1'b1;

        // Worked values, byte width
        apply(1'b1, 3'd0, 1'b0, 16'h004C, 16'h002D, " worked");
        check("R2 and", {result, 7'h0}, {16'h000C, 7'h0});
        apply(1'b1, 3'd1, 1'b0, 16'h004C, 16'h002D, " worked");
        check("R2 or", {result, 7'h0}, {16'h006D, 7'h0});
        apply(1'b1, 3'd2, 1'b0, 16'h004C, 16'h002D, " worked");
        check("R2 xor", {result, 7'h0}, {16'h0061, 7'h0});

        // Upper operand bits ignored in byte mode, used in word mode
        apply(1'b1, 3'd1, 1'b0, 16'hAB4C, 16'hFF2D, " R3");
        check("R3 narrow", {result, 7'h0}, {16'h006D, 7'h0});
        apply(1'b1, 3'd1, 1'b1, 16'hAB4C, 16'h0F2D, " R3");
        check("R3 wide", {result, 7'h0}, {16'hAF6D, 7'h0});

        // TEST sets zero flag, keeps result; NOT then preserves flags
        apply(1'b1, 3'd4, 1'b1, 16'h5555, 16'hAAAA, " R10");
        check("R10 zf", {15'h0, flag_zero, wr_en, 6'h0}, {15'h0, 1'b1, 1'b0, 6'h0});
        apply(1'b1, 3'd3, 1'b1, 16'h1234, 16'h0000, " R9");
        check("R9 not", {result, 7'h0}, {16'hEDCB, 7'h0});

        // Undefined codes and idle cycles
        for (int c = 5; c < 8; c++) apply(1'b1, 3'(c), 1'b1, 16'hFFFF, 16'hFFFF, " R11");
        apply(1'b0, 3'd0, 1'b0, 16'h0000, 16'h0000, " R11");

        // Byte sweep: every destination value against four masks, all ops
        for (int op = 0; op < 5; op++)
            for (int a = 0; a < 256; a++)
                for (int k = 0; k < 4; k++)
                    apply(1'b1, 3'(op), 1'b0, 16'((a * 37 + 16'hA500) & 16'hFFFF),
                          16'(((a * 37 + k * 91 + 5) & 255) | 16'h5A00), " R3 sweep8");

        // Word patterns, ops interleaved, with idles
        for (int i = 0; i < 400; i++) begin
            apply(1'b1, 3'(i % 5), 1'b1, 16'((i * 5417 + 3) & 16'hFFFF),
                  16'((i * 40503 + 77) & 16'hFFFF), " R3 sweep16");
            if (i % 7 == 0) apply(1'b0, 3'd1, 1'b1, 16'h0, 16'h0, " idle");
        end
        apply(1'b1, 3'd0, 1'b1, 16'h8001, 16'h8000, " R5 wide");
        apply(1'b1, 3'd0, 1'b0, 16'h0080, 16'h00FF, " R5 narrow");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1: actual run still busy, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule